// File: doc/BRIEF.md
# Half-Duplex Smart Card Channel

This block serves one contact smart card slot. It produces the card clock by dividing the system clock. It drives the card reset line at a level the host sets. It runs a single open-drain data wire in one direction at a time. One byte buffer serves both directions. The host fills it and starts a transmission. When the last character and its guard time are out, the block turns the wire around and collects what the card answers into the same buffer, starting again at address zero.

The host keeps full control of the card session. It decides when reset is asserted or released, sets the bit time in card clocks, and judges when an answer is complete from the byte count. The block holds no answer-to-reset parser, no speed negotiation and no block protocol. All timing comes from clock-enable pulses, so the buffer and every register run on the one system clock. The card clock output can feed a group of slots, while reset and data stay private to each slot.

Top module: `card_chan`

## Requirements
- R1: `card_clk_o` has a period of CLK_DIV system clocks (default 6) and is high for the first CLK_DIV/2 of them.
- R2: `card_rst_o` is 0 after reset and, one cycle after `cfg_we`, equals the `cfg_rst_lvl` written; nothing else changes it.
- R3: `status` is {card reset level, bit time}, where bit time is ETU_W bits in card clocks. It reads {0, 372} after reset and takes `cfg_etu` on `cfg_we`.
- R4: A `tx_start` pulse taken while not transmitting, with `tx_len` N > 0, sends buffer bytes at addresses 0 to N-1 in order. Each character is a 0 start bit, 8 data bits sent least significant bit first, and an even parity bit. Each bit lasts bit time x CLK_DIV system clocks.
- R5: After each parity bit the wire stays released for at least two bit times. Successive start edges are at least 12 bit times minus one card clock period apart.
- R6: `card_io_oe_o` (1 pulls the wire low) is 1 only during zero bits of a transmission, and it is 0 whenever `tx_busy` is 0.
- R7: `tx_start` is ignored while `tx_busy` is 1. A `tx_start` with `tx_len` = 0 sends nothing and leaves `tx_busy` at 0.
- R8: The receiver is off while `tx_busy` is 1, so the block's own characters are not stored. When a transmission ends, or on a zero-length start, the pointer returns to 0 and `rx_count` reads 0.
- R9: While not transmitting, a falling edge on `card_io_i` starts a character. Each bit is sampled near its middle. A low start bit stores the 8 data bits, least significant bit first, at the pointer, and `rx_count` then increases by one. The parity bit is not checked.
- R10: `rx_clear` while not transmitting returns the pointer and `rx_count` to 0.
- R11: The buffer keeps the first DEPTH (256) received bytes. Later characters are dropped, `rx_count` stops at DEPTH, and stored bytes are never overwritten.
- R12: `buf_we` writes `buf_wdata` at `buf_waddr`. `buf_rdata` shows the byte at `buf_raddr` one cycle after the address is applied, while `tx_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (33 MHz in service) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load bit time and reset level |
| cfg_etu | input | ETU_W | Bit time in card clocks |
| cfg_rst_lvl | input | 1 | Level to drive on the card reset line |
| buf_we | input | 1 | Host buffer write strobe |
| buf_waddr | input | log2(DEPTH) | Host write address |
| buf_wdata | input | 8 | Host write byte |
| buf_raddr | input | log2(DEPTH) | Host read address |
| buf_rdata | output | 8 | Registered read byte |
| tx_start | input | 1 | Start sending from address 0 |
| tx_len | input | log2(DEPTH)+1 | Number of bytes to send |
| rx_clear | input | 1 | Rewind receive pointer |
| tx_busy | output | 1 | Transmission in progress |
| rx_count | output | log2(DEPTH)+1 | Bytes received since pointer rewind |
| status | output | ETU_W+1 | {reset level, bit time} |
| card_clk_o | output | 1 | Divided card clock |
| card_rst_o | output | 1 | Card reset line |
| card_io_i | input | 1 | Sensed level of the data wire |
| card_io_oe_o | output | 1 | 1 pulls the data wire low |

## Verification
The assertions assume the host keeps the bit time at 2 or more and leaves it unchanged while a character is on the wire. They also assume `tx_len` never exceeds DEPTH and that no buffer write lands on an address the receiver is filling. The card model in the bench drives the wire only while the block's transmit monitor is off. It frames every character at exactly the programmed bit time, with a full two-bit guard. Bit time changes and buffer writes happen only between exchanges.

// File: rtl/card_chan_pkg.sv
package card_chan_pkg;
  // start + 8 data + parity + 2 guard bits
  localparam int FRAME_BITS = 12;

  typedef enum logic [2:0] {
    ST_RX_IDLE,
    ST_RX_BITS,
    ST_TX_LOAD,
    ST_TX_WAIT,
    ST_TX_BITS
  } chan_state_e;
endpackage

// File: rtl/card_clkgen.sv
module card_clkgen #(
  parameter int CLK_DIV = 6
) (
  input  logic clk,
  input  logic rst,
  output logic card_clk,
  output logic cen
);
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF  = CLK_DIV / 2;

  logic [CNT_W-1:0] cnt, nxt;

  assign nxt = (cnt == CNT_W'(CLK_DIV - 1)) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      card_clk <= 1'b0;
      cen      <= 1'b0;
    end else begin
      cnt      <= nxt;
      card_clk <= (nxt < CNT_W'(HALF));
      cen      <= (nxt == '0);
    end
  end

  AST_CLK_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(card_clk) |=> card_clk); // R1
  AST_CEN_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    cen |-> card_clk); // R1
endmodule

// File: rtl/chan_buf.sv
module chan_buf #(
  parameter int DEPTH = 256,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/chan_engine.sv
module chan_engine
  import card_chan_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int ETU_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cen,
  input  logic [ETU_W-1:0]         etu,
  input  logic                     tx_start,
  input  logic [$clog2(DEPTH):0]   tx_len,
  input  logic                     rx_clear,
  input  logic                     io_in,
  input  logic [7:0]               rd_data,
  output logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic                     rx_we,
  output logic [$clog2(DEPTH)-1:0] rx_addr,
  output logic [7:0]               rx_byte,
  output logic                     tx_busy,
  output logic                     io_oe,
  output logic [$clog2(DEPTH):0]   rx_count
);
  localparam int A_W   = $clog2(DEPTH);
  localparam int PTR_W = A_W + 1;
  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

  chan_state_e           state;
  logic [PTR_W-1:0]      ptr, len;
  logic [ETU_W-1:0]      ecnt, lim;
  logic [3:0]            bitn;
  logic [FRAME_BITS-1:0] frame;
  logic                  io_s1, io_s2, io_prev;
  logic                  tick;

  always_comb begin
    if (state == ST_RX_BITS && bitn == 4'd0) lim = (etu >> 1) - 1'b1;
    else                                     lim = etu - 1'b1;
    tick = cen && (ecnt == lim);
  end

  assign tx_busy  = (state == ST_TX_LOAD) || (state == ST_TX_WAIT) || (state == ST_TX_BITS);
  assign rd_addr  = ptr[A_W-1:0];
  assign rx_count = tx_busy ? '0 : ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RX_IDLE;
      ptr     <= '0;
      len     <= '0;
      ecnt    <= '0;
      bitn    <= '0;
      frame   <= '1;
      io_s1   <= 1'b1;
      io_s2   <= 1'b1;
      io_prev <= 1'b1;
      rx_we   <= 1'b0;
      rx_addr <= '0;
      rx_byte <= '0;
      io_oe   <= 1'b0;
    end else begin
      io_s1   <= io_in;
      io_s2   <= io_s1;
      io_prev <= io_s2;
      rx_we   <= 1'b0;
      io_oe   <= (state == ST_TX_BITS) && !frame[0];
      if (cen) ecnt <= tick ? '0 : ecnt + 1'b1;
      unique case (state)
        ST_RX_IDLE, ST_RX_BITS: begin
          if (tx_start) begin
            ptr <= '0;
            if (tx_len != '0) begin
              len   <= tx_len;
              state <= ST_TX_LOAD;
            end else begin
              state <= ST_RX_IDLE;
            end
          end else if (rx_clear) begin
            ptr   <= '0;
            state <= ST_RX_IDLE;
          end else if (state == ST_RX_IDLE) begin
            if (io_prev && !io_s2) begin
              state <= ST_RX_BITS;
              ecnt  <= '0;
              bitn  <= '0;
            end
          end else if (tick) begin
            bitn <= bitn + 1'b1;
            if (bitn == 4'd0) begin
              if (io_s2) state <= ST_RX_IDLE;
            end else if (bitn <= 4'd8) begin
              rx_byte <= {io_s2, rx_byte[7:1]};
            end else begin
              state <= ST_RX_IDLE;
              if (ptr != FULL) begin
                rx_we   <= 1'b1;
                rx_addr <= ptr[A_W-1:0];
                ptr     <= ptr + 1'b1;
              end
            end
          end
        end
        ST_TX_LOAD: state <= ST_TX_WAIT;
        ST_TX_WAIT: begin
          frame <= {2'b11, ^rd_data, rd_data, 1'b0};
          bitn  <= '0;
          ecnt  <= '0;
          state <= ST_TX_BITS;
        end
        ST_TX_BITS: begin
          if (tick) begin
            frame <= {1'b1, frame[FRAME_BITS-1:1]};
            bitn  <= bitn + 1'b1;
            if (bitn == 4'(FRAME_BITS - 1)) begin
              bitn <= '0;
              if (ptr + 1'b1 == len) begin
                ptr   <= '0;
                state <= ST_RX_IDLE;
              end else begin
                ptr   <= ptr + 1'b1;
                state <= ST_TX_LOAD;
              end
            end
          end
        end
        default: state <= ST_RX_IDLE;
      endcase
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> !io_oe); // R6
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    ptr <= FULL); // R11
  AST_RX_STEP: assert property (@(posedge clk) disable iff (rst)
    rx_we |-> (ptr == PTR_W'($past(ptr) + 1'b1))); // R9
  AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (rst)
    tx_busy |-> !rx_we); // R8
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && tx_start) |=> $stable(len)); // R7
endmodule

// File: rtl/card_chan.sv
module card_chan #(
  parameter int DEPTH     = 256,
  parameter int CLK_DIV   = 6,
  parameter int ETU_W     = 16,
  parameter int ETU_RESET = 372
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [ETU_W-1:0]         cfg_etu,
  input  logic                     cfg_rst_lvl,
  input  logic                     buf_we,
  input  logic [$clog2(DEPTH)-1:0] buf_waddr,
  input  logic [7:0]               buf_wdata,
  input  logic [$clog2(DEPTH)-1:0] buf_raddr,
  output logic [7:0]               buf_rdata,
  input  logic                     tx_start,
  input  logic [$clog2(DEPTH):0]   tx_len,
  input  logic                     rx_clear,
  output logic                     tx_busy,
  output logic [$clog2(DEPTH):0]   rx_count,
  output logic [ETU_W:0]           status,
  output logic                     card_clk_o,
  output logic                     card_rst_o,
  input  logic                     card_io_i,
  output logic                     card_io_oe_o
);
  localparam int A_W = $clog2(DEPTH);

  logic [ETU_W-1:0] etu_q;
  logic             rst_q;
  logic             cen;
  logic             rx_we, mem_we;
  logic [A_W-1:0]   eng_raddr, rx_addr, mem_waddr, mem_raddr;
  logic [7:0]       rx_byte, mem_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      etu_q <= ETU_W'(ETU_RESET);
      rst_q <= 1'b0;
    end else if (cfg_we) begin
      etu_q <= cfg_etu;
      rst_q <= cfg_rst_lvl;
    end
  end

  assign card_rst_o = rst_q;
  assign status     = {rst_q, etu_q};
  assign mem_we     = rx_we | buf_we;
  assign mem_waddr  = rx_we ? rx_addr : buf_waddr;
  assign mem_wdata  = rx_we ? rx_byte : buf_wdata;
  assign mem_raddr  = tx_busy ? eng_raddr : buf_raddr;

  card_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk(clk), .rst(rst), .card_clk(card_clk_o), .cen(cen)
  );

  chan_buf #(.DEPTH(DEPTH), .W(8)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(buf_rdata)
  );

  chan_engine #(.DEPTH(DEPTH), .ETU_W(ETU_W)) u_engine (
    .clk(clk), .rst(rst), .cen(cen), .etu(etu_q),
    .tx_start(tx_start), .tx_len(tx_len), .rx_clear(rx_clear),
    .io_in(card_io_i), .rd_data(buf_rdata), .rd_addr(eng_raddr),
    .rx_we(rx_we), .rx_addr(rx_addr), .rx_byte(rx_byte),
    .tx_busy(tx_busy), .io_oe(card_io_oe_o), .rx_count(rx_count)
  );

  AST_RST_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (card_rst_o == $past(cfg_rst_lvl))); // R2
endmodule

// File: tb/card_chan_bench.sv
`timescale 1ns/1ps
module card_chan_bench;
  localparam int DEPTH   = 256;
  localparam int CLK_DIV = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_rst_lvl = 1'b0;
  logic [15:0] cfg_etu = '0;
  logic buf_we = 1'b0;
  logic [7:0] buf_waddr = '0, buf_wdata = '0, buf_raddr = '0;
  logic [7:0] buf_rdata;
  logic tx_start = 1'b0, rx_clear = 1'b0;
  logic [8:0] tx_len = '0;
  logic tx_busy, card_clk_o, card_rst_o, card_io_oe_o;
  logic [8:0] rx_count;
  logic [16:0] status;
  logic card_drv = 1'b1;
  wire  io = card_io_oe_o ? 1'b0 : card_drv;

  int nchk = 0, nfail = 0, cyc = 0, bit_cyc = 24, tx_seen = 0, last_start = -1;
  bit mon_en = 1'b0, done = 1'b0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  card_chan #(.DEPTH(DEPTH), .CLK_DIV(CLK_DIV)) u_card_chan (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_etu(cfg_etu), .cfg_rst_lvl(cfg_rst_lvl),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .tx_start(tx_start), .tx_len(tx_len),
    .rx_clear(rx_clear), .tx_busy(tx_busy), .rx_count(rx_count), .status(status),
    .card_clk_o(card_clk_o), .card_rst_o(card_rst_o), .card_io_i(io),
    .card_io_oe_o(card_io_oe_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  task automatic cfg(input int etu, input bit lvl);
    cfg_etu = 16'(etu); cfg_rst_lvl = lvl; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    bit_cyc = etu * CLK_DIV;
  endtask

  task automatic buf_wr(input int a, input logic [7:0] d);
    buf_waddr = 8'(a); buf_wdata = d; buf_we = 1'b1;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic buf_rd(input int a, output logic [7:0] d);
    buf_raddr = 8'(a);
    @(negedge clk); d = buf_rdata;
  endtask

  // driver: load buffer, queue expected characters, start sending
  task automatic send_bytes(input logic [7:0] b[$]);
    foreach (b[i]) begin
      buf_wr(i, b[i]);
      exp_tx.push_back(b[i]);
    end
    last_start = -1; mon_en = 1'b1;
    tx_len = 9'(b.size()); tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic wait_tx_done();
    repeat (3) @(negedge clk);
    while (tx_busy) @(negedge clk);
    mon_en = 1'b0;
  endtask

  // card model: drive one character at the programmed bit time
  task automatic card_tx(input logic [7:0] b, input bit keep);
    if (keep) exp_rx.push_back(b);
    card_drv = 1'b0; repeat (bit_cyc) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      card_drv = b[k]; repeat (bit_cyc) @(negedge clk);
    end
    card_drv = ^b; repeat (bit_cyc) @(negedge clk);
    card_drv = 1'b1; repeat (2 * bit_cyc) @(negedge clk);
  endtask

  task automatic check_rx(input int n, input string tag);
    logic [7:0] d, e;
    for (int i = 0; i < n; i++) begin
      buf_rd(i, d);
      e = exp_rx.pop_front();
      chk(d == e, tag, int'(d), int'(e));
    end
  endtask

  // monitor: decode characters on the wire and compare with the queue
  initial begin
    logic prev;
    logic [7:0] b, e;
    logic s, p;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (mon_en && prev && !io) begin
        if (last_start >= 0)
          chk(cyc - last_start >= 12 * bit_cyc - CLK_DIV + 1, "R5 start edge spacing",
              cyc - last_start, 12 * bit_cyc - CLK_DIV + 1);
        last_start = cyc;
        repeat (bit_cyc / 2) @(negedge clk);
        s = io;
        for (int k = 0; k < 8; k++) begin
          repeat (bit_cyc) @(negedge clk);
          b[k] = io;
        end
        repeat (bit_cyc) @(negedge clk);
        p = io;
        if (exp_tx.size() == 0) begin
          chk(1'b0, "R4 unexpected character", int'(b), -1);
        end else begin
          e = exp_tx.pop_front();
          chk(s == 1'b0 && b == e, "R4 transmitted byte", int'(b), int'(e));
        end
        chk(p == ^b, "R4 even parity bit", int'(p), int'(^b));
        tx_seen++;
      end
      prev = io;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] q[$];
    int hi, lo;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    chk(status == 17'd372, "R3 status after reset", int'(status), 372);
    chk(card_rst_o == 1'b0, "R2 reset line after reset", int'(card_rst_o), 0);
    chk(card_io_oe_o == 1'b0 && tx_busy == 1'b0, "R6 wire released after reset", int'(card_io_oe_o), 0);
    chk(rx_count == 9'd0, "R10 count after reset", int'(rx_count), 0);

    // R1 card clock shape
    while (card_clk_o) @(negedge clk);
    while (!card_clk_o) @(negedge clk);
    hi = 0; lo = 0;
    while (card_clk_o) begin hi++; @(negedge clk); end
    while (!card_clk_o) begin lo++; @(negedge clk); end
    chk(hi == CLK_DIV / 2, "R1 card clock high time", hi, CLK_DIV / 2);
    chk(hi + lo == CLK_DIV, "R1 card clock period", hi + lo, CLK_DIV);

    cfg(4, 1'b1);
    chk(card_rst_o == 1'b1, "R2 reset line follows host", int'(card_rst_o), 1);
    chk(status == {1'b1, 16'd4}, "R3 status after write", int'(status), 65540);

    buf_wr(9, 8'hC3);
    buf_rd(9, d);
    chk(d == 8'hC3, "R12 buffer read back", int'(d), 'hC3);

    // R4 R5 R7: three characters, a start during busy is ignored
    q = '{8'h3C, 8'h01, 8'hA7};
    send_bytes(q);
    repeat (60) @(negedge clk);
    tx_len = 9'd1; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    chk(tx_busy == 1'b1, "R7 still busy after ignored start", int'(tx_busy), 1);
    wait_tx_done();
    repeat (10 * bit_cyc) @(negedge clk);
    chk(tx_seen == 3, "R7 characters sent", tx_seen, 3);
    chk(exp_tx.size() == 0, "R4 all queued characters seen", exp_tx.size(), 0);
    chk(card_io_oe_o == 1'b0, "R6 released after transmit", int'(card_io_oe_o), 0);
    chk(rx_count == 9'd0, "R8 own characters not received", int'(rx_count), 0);

    // R9 reception
    card_tx(8'h3B, 1'b1); card_tx(8'h9F, 1'b1); card_tx(8'h00, 1'b1); card_tx(8'h5A, 1'b1);
    chk(rx_count == 9'd4, "R9 received count", int'(rx_count), 4);
    check_rx(4, "R9 received byte");

    // R10 rewind
    rx_clear = 1'b1; @(negedge clk); rx_clear = 1'b0;
    chk(rx_count == 9'd0, "R10 count after clear", int'(rx_count), 0);

    // R7 R8 zero-length start
    card_tx(8'h61, 1'b1);
    chk(rx_count == 9'd1, "R9 single byte count", int'(rx_count), 1);
    check_rx(1, "R9 single byte");
    tx_len = 9'd0; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    chk(tx_busy == 1'b0, "R7 zero length not busy", int'(tx_busy), 0);
    chk(rx_count == 9'd0, "R8 zero length rewinds", int'(rx_count), 0);

    // R11 capacity at a faster bit time
    cfg(2, 1'b1);
    for (int i = 0; i < DEPTH + 2; i++)
      card_tx((i < DEPTH) ? 8'(i * 7 + 3) : 8'hEE, i < DEPTH);
    chk(rx_count == 9'd256, "R11 count saturates", int'(rx_count), 256);
    check_rx(DEPTH, "R11 stored byte");

    // R4 faster bit time on transmit
    tx_seen = 0;
    q = '{8'hB5};
    send_bytes(q);
    wait_tx_done();
    chk(tx_seen == 1, "R4 character at new bit time", tx_seen, 1);

    done = 1'b1;
    report();
    $finish;
  end
endmodule